// File: doc/BRIEF.md
# Socket Vector Apply and Compare Engine

This block runs one functional test vector at a time against a device in a 20-position test socket. A smaller device is seated so that its first pin lands on socket pin 1 and its last on socket pin 20. Unused positions in between are no-connects. Each vector carries five control words:
- a direction word that says which pins the tester drives and which it senses;
- the drive levels;
- the expected response;
- a clock-pulse mask;
- a two-bit code that routes ground to one socket pin.

Once a vector is accepted, the engine does the following in order:
1. It applies the directions and drive levels and waits a programmable settle time.
2. It raises the masked pins for a programmable width and waits again.
3. It samples every sensed pin and compares the samples with the expected levels.

If the mask is empty, the pulse phase is skipped. The result is a per-vector pass flag and a per-pin mismatch vector, plus a sticky group mismatch vector that collects failing pins across a whole test group. A device is good only if the group vector stays zero.

Top module: `socket_vec_engine`

## Requirements
- R1: After reset all socket pins are released (`pin_oe_o` and `pin_drv_o` zero), `vec_ready_o` is 1, `busy_o` and `vec_done_o` are 0, `vec_mism_o` and `grp_mism_o` are zero, and `vec_pass_o` and `grp_pass_o` are 1.
- R2: Bit i of every pin vector is socket pin i+1. A direction bit of 1 drives that pin with its drive level (1 high, 0 low). A direction bit of 0 senses it. A sensed pin always has `pin_drv_o` low. Pin settings change only in the cycle after a vector is accepted and are held until the next acceptance.
- R3: The ground code selects one pin: 0 selects socket pin 7 (bit 6), 1 selects pin 8, 2 selects pin 9 and 3 selects pin 10 (bit 9). That pin is driven low regardless of its direction, drive and mask bits, and it is never compared.
- R4: The settle and pulse-width counts s and w are captured at acceptance. If the accept edge is edge 0 and the mask is non-zero, the first wait lasts s+1 cycles, the pulse lasts w+1 cycles and the second wait lasts s+1 cycles. `vec_done_o` is then high after edge 2s+w+4.
- R5: During the pulse phase only, every masked pin that is driven and not grounded is driven high. At all other times it carries its drive level.
- R6: With an all-zero mask, the pulse and the second wait are skipped and `vec_done_o` is high after edge s+2.
- R7: At sampling, `vec_mism_o` becomes (sampled XOR expected) restricted to sensed pins, and `vec_pass_o` is 1 exactly when that vector is zero. Both hold until the next result.
- R8: `grp_mism_o` is the OR of all vector mismatch vectors since the last honoured `grp_start_i`, and `grp_pass_o` is 1 exactly when it is zero. `grp_start_i` clears it only while the engine is idle.
- R9: A vector is taken only on a cycle with `vec_valid_i` and `vec_ready_o` both high. While busy, `vec_ready_o` is 0 and `vec_valid_i` has no effect on the pins. `vec_done_o` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| grp_start_i | input | 1 | Clear the group result (honoured when idle) |
| vec_valid_i | input | 1 | Vector fields are valid |
| vec_ready_o | output | 1 | Engine idle, vector can be taken |
| vec_dir_i | input | NPINS | Direction word, 1 = drive, 0 = sense |
| vec_drv_i | input | NPINS | Drive levels |
| vec_exp_i | input | NPINS | Expected levels on sensed pins |
| vec_clk_mask_i | input | NPINS | Pins to pulse high |
| vec_gnd_sel_i | input | GND_W | Ground pin code |
| settle_cnt_i | input | CNT_W | Settle count s |
| pulse_w_i | input | CNT_W | Pulse width count w |
| busy_o | output | 1 | Vector in progress |
| vec_done_o | output | 1 | One-cycle result strobe |
| vec_pass_o | output | 1 | Last vector matched |
| vec_mism_o | output | NPINS | Last vector per-pin mismatch |
| grp_mism_o | output | NPINS | Accumulated failing pins of the group |
| grp_pass_o | output | 1 | No failing pin in the group |
| pin_oe_o | output | NPINS | Per-pin drive enable |
| pin_drv_o | output | NPINS | Per-pin driven level |
| pin_in_i | input | NPINS | Sampled socket levels |

## Verification
A device model with a clocked output and an inverting output makes results depend on whether the pulse was issued. If the pulse phase were skipped wrongly, or run with an empty mask, the latched output would read back wrong and the measured latency would differ. The ground code is driven onto a pin whose drive and mask bits are set. A design that let the mask or direction win would show the pin going high or being compared. A vector presented while busy, together with a changed settle count and a group clear, exposes a design that re-latches fields mid-run or clears the group while busy. An injected stuck-at-0 fault shows whether mismatches are reported per pin and kept across the group.

// File: rtl/socket_vec_pkg.sv
`timescale 1ns/1ps
package socket_vec_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SET1,
    ST_PULSE,
    ST_SET2,
    ST_SAMPLE
  } seq_st_e;
endpackage

// File: rtl/sv_seq.sv
`timescale 1ns/1ps
module sv_seq import socket_vec_pkg::*; #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             accept_i,
  input  logic             pulse_req_i,
  input  logic [CNT_W-1:0] settle_i,
  input  logic [CNT_W-1:0] pw_i,
  output logic             ready_o,
  output logic             pulse_on_o,
  output logic             sample_o
);
  seq_st_e          st_q, st_d;
  logic [CNT_W-1:0] cnt_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:   if (accept_i) st_d = ST_SET1;
      ST_SET1:   if (cnt_q == settle_i) st_d = pulse_req_i ? ST_PULSE : ST_SAMPLE;
      ST_PULSE:  if (cnt_q == pw_i) st_d = ST_SET2;
      ST_SET2:   if (cnt_q == settle_i) st_d = ST_SAMPLE;
      ST_SAMPLE: st_d = ST_IDLE;
      default:   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= (st_d != st_q) ? '0 : cnt_q + 1'b1;
    end
  end

  assign ready_o    = (st_q == ST_IDLE);
  assign pulse_on_o = (st_q == ST_PULSE);
  assign sample_o   = (st_q == ST_SAMPLE);
endmodule

// File: rtl/sv_pin_drive.sv
`timescale 1ns/1ps
module sv_pin_drive #(
  parameter int NPINS   = 20,
  parameter int GND_W   = 2,
  parameter int GND_IDX = 6
) (
  input  logic             loaded_i,
  input  logic [NPINS-1:0] dir_i,
  input  logic [NPINS-1:0] drv_i,
  input  logic [NPINS-1:0] mask_i,
  input  logic [GND_W-1:0] gnd_sel_i,
  input  logic             pulse_on_i,
  output logic [NPINS-1:0] oe_o,
  output logic [NPINS-1:0] drv_o,
  output logic [NPINS-1:0] sense_o
);
  localparam int GND_N = 1 << GND_W;

  logic [NPINS-1:0] is_gnd;

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    if (i >= GND_IDX && i < GND_IDX + GND_N) begin : g_gnd
      assign is_gnd[i] = (gnd_sel_i == GND_W'(i - GND_IDX));
    end else begin : g_sig
      assign is_gnd[i] = 1'b0;
    end
    // ground wins over direction, level and pulse
    assign oe_o[i]    = loaded_i & (dir_i[i] | is_gnd[i]);
    assign drv_o[i]   = oe_o[i] & ~is_gnd[i] & (drv_i[i] | (pulse_on_i & mask_i[i]));
    assign sense_o[i] = ~(dir_i[i] | is_gnd[i]);
  end
endmodule

// File: rtl/sv_compare.sv
`timescale 1ns/1ps
module sv_compare #(
  parameter int NPINS = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sample_i,
  input  logic             grp_clr_i,
  input  logic [NPINS-1:0] pins_i,
  input  logic [NPINS-1:0] exp_i,
  input  logic [NPINS-1:0] sense_i,
  output logic             done_o,
  output logic             pass_o,
  output logic [NPINS-1:0] mism_o,
  output logic [NPINS-1:0] grp_mism_o
);
  logic [NPINS-1:0] mism_d, mism_q, grp_q;
  logic             done_q;

  assign mism_d = (pins_i ^ exp_i) & sense_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mism_q <= '0;
      grp_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= sample_i;
      if (sample_i) begin
        mism_q <= mism_d;
        grp_q  <= grp_q | mism_d;
      end else if (grp_clr_i) begin
        grp_q  <= '0;
      end
    end
  end

  assign done_o     = done_q;
  assign mism_o     = mism_q;
  assign pass_o     = ~|mism_q;
  assign grp_mism_o = grp_q;
endmodule

// File: rtl/socket_vec_engine.sv
`timescale 1ns/1ps
module socket_vec_engine #(
  parameter int NPINS        = 20,
  parameter int CNT_W        = 8,
  parameter int GND_W        = 2,
  parameter int GND_BASE_PIN = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             grp_start_i,
  input  logic             vec_valid_i,
  output logic             vec_ready_o,
  input  logic [NPINS-1:0] vec_dir_i,
  input  logic [NPINS-1:0] vec_drv_i,
  input  logic [NPINS-1:0] vec_exp_i,
  input  logic [NPINS-1:0] vec_clk_mask_i,
  input  logic [GND_W-1:0] vec_gnd_sel_i,
  input  logic [CNT_W-1:0] settle_cnt_i,
  input  logic [CNT_W-1:0] pulse_w_i,
  output logic             busy_o,
  output logic             vec_done_o,
  output logic             vec_pass_o,
  output logic [NPINS-1:0] vec_mism_o,
  output logic [NPINS-1:0] grp_mism_o,
  output logic             grp_pass_o,
  output logic [NPINS-1:0] pin_oe_o,
  output logic [NPINS-1:0] pin_drv_o,
  input  logic [NPINS-1:0] pin_in_i
);
  localparam int GND_IDX = GND_BASE_PIN - 1;

  logic [NPINS-1:0] dir_q, drv_q, exp_q, mask_q, sense;
  logic [GND_W-1:0] gnd_q;
  logic [CNT_W-1:0] settle_q, pw_q;
  logic             loaded_q, ready, accept, pulse_on, sample;

  assign accept = vec_valid_i & ready;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q    <= '0;
      drv_q    <= '0;
      exp_q    <= '0;
      mask_q   <= '0;
      gnd_q    <= '0;
      settle_q <= '0;
      pw_q     <= '0;
      loaded_q <= 1'b0;
    end else if (accept) begin
      dir_q    <= vec_dir_i;
      drv_q    <= vec_drv_i;
      exp_q    <= vec_exp_i;
      mask_q   <= vec_clk_mask_i;
      gnd_q    <= vec_gnd_sel_i;
      settle_q <= settle_cnt_i;
      pw_q     <= pulse_w_i;
      loaded_q <= 1'b1;
    end
  end

  sv_seq #(.CNT_W(CNT_W)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .accept_i    (accept),
    .pulse_req_i (|mask_q),
    .settle_i    (settle_q),
    .pw_i        (pw_q),
    .ready_o     (ready),
    .pulse_on_o  (pulse_on),
    .sample_o    (sample)
  );

  sv_pin_drive #(.NPINS(NPINS), .GND_W(GND_W), .GND_IDX(GND_IDX)) u_pins (
    .loaded_i   (loaded_q),
    .dir_i      (dir_q),
    .drv_i      (drv_q),
    .mask_i     (mask_q),
    .gnd_sel_i  (gnd_q),
    .pulse_on_i (pulse_on),
    .oe_o       (pin_oe_o),
    .drv_o      (pin_drv_o),
    .sense_o    (sense)
  );

  sv_compare #(.NPINS(NPINS)) u_cmp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sample_i   (sample),
    .grp_clr_i  (grp_start_i & ready),
    .pins_i     (pin_in_i),
    .exp_i      (exp_q),
    .sense_i    (sense),
    .done_o     (vec_done_o),
    .pass_o     (vec_pass_o),
    .mism_o     (vec_mism_o),
    .grp_mism_o (grp_mism_o)
  );

  assign vec_ready_o = ready;
  assign busy_o      = ~ready;
  assign grp_pass_o  = ~|grp_mism_o;
endmodule

// File: rtl/socket_vec_engine_chk.sv
`timescale 1ns/1ps
module socket_vec_engine_chk #(
  parameter int NPINS   = 20,
  parameter int GND_W   = 2,
  parameter int GND_IDX = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             vec_valid_i,
  input logic             vec_ready_o,
  input logic             vec_done_o,
  input logic [NPINS-1:0] vec_mism_o,
  input logic [NPINS-1:0] grp_mism_o,
  input logic [NPINS-1:0] pin_oe_o,
  input logic [NPINS-1:0] pin_drv_o,
  input logic             loaded_q,
  input logic [GND_W-1:0] gnd_q
);
  localparam int PW = $clog2(NPINS);
  logic [PW-1:0] gidx;
  assign gidx = PW'(GND_IDX) + PW'(gnd_q);

  assert_gnd_low_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loaded_q |-> (pin_oe_o[gidx] && !pin_drv_o[gidx]));

  assert_sense_undriven_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_drv_o & ~pin_oe_o) == '0);

  assert_pins_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(vec_valid_i && vec_ready_o) |=> $stable(pin_oe_o));

  assert_done_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_done_o |=> !vec_done_o);

  assert_mism_sensed_only_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_done_o |-> (vec_mism_o & pin_oe_o) == '0);

  assert_grp_covers_vec_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_done_o |-> (vec_mism_o & ~grp_mism_o) == '0);
endmodule

bind socket_vec_engine socket_vec_engine_chk #(
  .NPINS(NPINS), .GND_W(GND_W), .GND_IDX(GND_BASE_PIN - 1)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .vec_valid_i (vec_valid_i),
  .vec_ready_o (vec_ready_o),
  .vec_done_o  (vec_done_o),
  .vec_mism_o  (vec_mism_o),
  .grp_mism_o  (grp_mism_o),
  .pin_oe_o    (pin_oe_o),
  .pin_drv_o   (pin_drv_o),
  .loaded_q    (loaded_q),
  .gnd_q       (gnd_q)
);

// File: tb/socket_vec_engine_tb.sv
`timescale 1ns/1ps
module socket_vec_engine_tb;
  localparam int N = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          grp_start = 1'b0, vvalid = 1'b0;
  logic [N-1:0]  vdir = '0, vdrv = '0, vexp = '0, vmask = '0;
  logic [1:0]    vgnd = '0;
  logic [7:0]    settle = '0, pw = '0;
  logic          ready, busy, done, vpass, gpass;
  logic [N-1:0]  vmism, gmism, oe, drv, pin_in;
  logic [N-1:0]  sa0 = '0;

  socket_vec_engine u_dut (
    .clk_i(clk), .rst_ni(rst_n), .grp_start_i(grp_start), .vec_valid_i(vvalid),
    .vec_ready_o(ready), .vec_dir_i(vdir), .vec_drv_i(vdrv), .vec_exp_i(vexp),
    .vec_clk_mask_i(vmask), .vec_gnd_sel_i(vgnd), .settle_cnt_i(settle),
    .pulse_w_i(pw), .busy_o(busy), .vec_done_o(done), .vec_pass_o(vpass),
    .vec_mism_o(vmism), .grp_mism_o(gmism), .grp_pass_o(gpass),
    .pin_oe_o(oe), .pin_drv_o(drv), .pin_in_i(pin_in)
  );

  // device model: pin1 D, pin2 clock, pin3 Q (latched on clock rise), pin4 = not D
  logic q_dev = 1'b0;
  always @(posedge drv[1]) if (oe[1]) q_dev <= drv[0];
  always_comb begin
    pin_in    = oe & drv;
    pin_in[2] = q_dev;
    pin_in[3] = ~drv[0];
    pin_in    = pin_in & ~sa0;
  end

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // runs one vector; lat = edges after accept until done visible, hi = cycles pin w high
  task automatic run_vec(input logic [N-1:0] d, input logic [N-1:0] l, input logic [N-1:0] e,
                         input logic [N-1:0] m, input logic [1:0] g, input int s, input int w,
                         input int watch, input bit poke, output int lat, output int hi);
    logic [N-1:0] oe_snap;
    @(negedge clk);
    vdir = d; vdrv = l; vexp = e; vmask = m; vgnd = g;
    settle = 8'(s); pw = 8'(w); vvalid = 1'b1;
    @(posedge clk);
    lat = 0; hi = 0;
    forever begin
      @(negedge clk);
      if (lat == 0) begin vvalid = 1'b0; oe_snap = oe; end
      if (poke && lat == 2) begin
        vvalid = 1'b1; vdir = '0; settle = 8'd7; grp_start = 1'b1;
      end
      if (poke && lat == 3) begin
        chk(oe == oe_snap, "R9 pins unchanged by valid while busy", 32'(oe), 32'(oe_snap));
        chk(ready == 1'b0, "R9 not ready while busy", 32'(ready), 0);
        vvalid = 1'b0; grp_start = 1'b0; settle = 8'(s);
      end
      if (done) break;
      if (drv[watch]) hi++;
      @(posedge clk);
      lat++;
    end
  endtask

  localparam int NV = 6;
  localparam logic [N-1:0] T_DIR  [NV] = '{20'hFFFF3, 20'hFFFF3, 20'hFFFF3, 20'hFFFF3, 20'hFFFE3, 20'hFFF73};
  localparam logic [N-1:0] T_DRV  [NV] = '{20'h00001, 20'h00000, 20'h00000, 20'h00001, 20'h00001, 20'h00001};
  localparam logic [N-1:0] T_EXP  [NV] = '{20'h00004, 20'h0000C, 20'h00008, 20'h0000C, 20'h00010, 20'h00080};
  localparam logic [N-1:0] T_MASK [NV] = '{20'h00002, 20'h00000, 20'h00002, 20'h00000, 20'h00000, 20'h00000};
  localparam logic [1:0]   T_GND  [NV] = '{2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd1};
  localparam logic [N-1:0] T_MISM [NV] = '{20'h00000, 20'h00000, 20'h00000, 20'h0000C, 20'h00010, 20'h00000};

  initial begin
    int lat, hi;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(oe == '0 && drv == '0, "R1 pins released", 32'({oe, drv}), 0);
    chk(ready && !busy && !done, "R1 handshake idle", {29'd0, ready, busy, done}, 32'h4);
    chk(vmism == '0 && gmism == '0 && vpass && gpass, "R1 results clear",
        32'(gmism), 0);
    rst_n = 1'b1;
    @(negedge clk);
    grp_start = 1'b1;
    @(negedge clk);
    grp_start = 1'b0;

    // table walk: s=2, w=1
    for (int i = 0; i < NV; i++) begin
      run_vec(T_DIR[i], T_DRV[i], T_EXP[i], T_MASK[i], T_GND[i], 2, 1, 1, 0, lat, hi);
      chk(vmism == T_MISM[i], $sformatf("R7 mismatch vector %0d", i), 32'(vmism), 32'(T_MISM[i]));
      chk(vpass == (T_MISM[i] == '0), $sformatf("R7 pass flag %0d", i), 32'(vpass), 32'(T_MISM[i] == '0));
      if (T_MASK[i] != '0) begin
        chk(lat == 9, $sformatf("R4 latency %0d", i), 32'(lat), 9);
        chk(hi == 2, $sformatf("R5 pulse width %0d", i), 32'(hi), 2);
      end else begin
        chk(lat == 4, $sformatf("R6 skipped pulse latency %0d", i), 32'(lat), 4);
        chk(hi == 0, $sformatf("R6 no pulse %0d", i), 32'(hi), 0);
      end
    end
    chk(gmism == 20'h0001C, "R8 group accumulation", 32'(gmism), 32'h1C);
    chk(gpass == 1'b0, "R8 group fails", 32'(gpass), 0);
    // after last table vector: ground code 1 -> socket pin 8 (bit 7)
    chk(oe[7] && !drv[7], "R3 pin 8 grounded", {30'd0, oe[7], drv[7]}, 2);
    chk(!oe[2] && !drv[2] && oe[0] && drv[0], "R2 sense/drive pins held",
        {28'd0, oe[2], drv[2], oe[0], drv[0]}, 3);

    // R3 ground on pin 10 overrides drive and mask bits
    run_vec(20'hFFFF3, 20'h00201, 20'h00000, 20'h00200, 2'd3, 1, 2, 9, 0, lat, hi);
    chk(hi == 0, "R3 grounded pin never high", 32'(hi), 0);
    chk(lat == 8, "R4 latency with mask s=1 w=2", 32'(lat), 8);
    chk(vmism == '0, "R3 grounded pin not compared", 32'(vmism), 0);
    chk(oe[9] && !drv[9], "R3 pin 10 driven low", {30'd0, oe[9], drv[9]}, 2);

    // R4/R5 s=0, w=3, clock rise latches D=1
    run_vec(20'hFFFF3, 20'h00001, 20'h00004, 20'h00002, 2'd0, 0, 3, 1, 0, lat, hi);
    chk(lat == 7, "R4 latency s=0 w=3", 32'(lat), 7);
    chk(hi == 4, "R5 pulse width w=3", 32'(hi), 4);
    chk(vmism == '0, "R5 pulse latched device", 32'(vmism), 0);
    @(negedge clk);
    chk(done == 1'b0, "R9 done single cycle", 32'(done), 0);

    // R8 clear when idle
    grp_start = 1'b1;
    @(negedge clk);
    grp_start = 1'b0;
    chk(gmism == '0 && gpass, "R8 group cleared", 32'(gmism), 0);

    // R7 stuck-at-0 on pin 4: Q=1, NQ expected 1
    sa0 = 20'h00008;
    run_vec(20'hFFFF3, 20'h00000, 20'h0000C, 20'h00000, 2'd0, 2, 0, 1, 0, lat, hi);
    chk(vmism == 20'h00008, "R7 stuck pin reported", 32'(vmism), 8);
    chk(!vpass, "R7 fail flag", 32'(vpass), 0);
    sa0 = '0;

    // R9/R8 interference while busy: valid, changed settle and group clear ignored
    run_vec(20'hFFFF3, 20'h00000, 20'h0000C, 20'h00000, 2'd0, 2, 0, 1, 1, lat, hi);
    chk(lat == 4, "R4 settle captured at accept", 32'(lat), 4);
    chk(vmism == '0, "R7 clean vector passes", 32'(vmism), 0);
    chk(gmism == 20'h00008, "R8 clear ignored while busy", 32'(gmism), 8);
    chk(oe == 20'hFFFF3, "R9 next vector not taken while busy", 32'(oe), 32'hFFFF3);

    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule